// File: doc/BRIEF.md
# Serial/Parallel Divider Configuration Loader

This block holds the control word of a clock synthesizer: a 9-bit feedback divide value, a 2-bit output divide select and two test-select bits. The word can come from dedicated parallel pins, which are followed while an active-low parallel strobe is low and frozen when it rises. It can also come from a three-wire serial port made of a data line, a clock line and a load line. The PLL and the dividers lie outside the block. The feedback divider output and the synthesized clock arrive as plain inputs and only feed the TEST output multiplexer.

All four strobe and serial lines are asynchronous. Each passes through a two-flop synchronizer into the system clock domain, and all edge detection happens there. A settings change therefore appears a few system clocks after the pin event that causes it.

At reset the register takes whatever is present on the parallel pins, so hardwired pins act as the power-up default. A range flag reports feedback values that the loop cannot lock to. The value is still applied.

Top module: `clk_cfg_loader`

## Requirements
- R1: During and directly after reset, `m_val`/`n_sel` equal `par_m`/`par_n`, the test bits are 00, and `test_out` is 0.
- R2: While `pload_n` is low, `m_val` and `n_sel` follow `par_m` and `par_n`, including changes made while the strobe stays low.
- R3: After `pload_n` rises, `m_val` and `n_sel` hold the captured values even when `par_m`/`par_n` change.
- R4: With `pload_n` high, each rising edge of `ser_clk` shifts `ser_dat` into a 14-bit register. The first bit ends up in the most significant position. A 14-bit frame is sent in the order T1, T0, N1, N0, M0 to M5, one ignored slot, then M6 to M8. A rising edge of `ser_ld` copies the decoded frame into `m_val`, `n_sel` and the test bits.
- R5: While `ser_ld` stays high, every rising edge of `ser_clk` shifts and also updates the settings from the new register contents.
- R6: After `ser_ld` falls, further serial clocking changes the shift register but leaves `m_val` and `n_sel` unchanged.
- R7: Outside parallel mode, `test_out` is chosen by the test bits {T1,T0}: 00 gives 0, 01 gives the shift register MSB, 10 gives `fb_div_in` and 11 gives `out_clk_in`.
- R8: `test_out` is 0 from the moment `pload_n` is seen low until the next serial transfer, whatever the test bits are.
- R9: `m_range_err` is 1 exactly when `m_val` is below 10 or above 28. The out-of-range value is still presented on `m_val`.
- R10: Serial clocking with no rising edge of `ser_ld` leaves settings captured in parallel mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| pload_n | input | 1 | Active-low parallel load strobe (asynchronous) |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel output divide select |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data |
| ser_ld | input | 1 | Serial load line (asynchronous) |
| fb_div_in | input | 1 | Feedback divider output, for TEST |
| out_clk_in | input | 1 | Synthesized output clock, for TEST |
| m_val | output | 9 | Feedback divide setting in force |
| n_sel | output | 2 | Output divide select in force |
| test_out | output | 1 | TEST multiplexer output |
| m_range_err | output | 1 | Feedback value outside lock range |

## Verification
The hardest case to reach is the pass-through mode. There `ser_ld` is raised before any data is clocked, and the settings must track the shift register edge by edge without another load edge. The bench raises the load line first and then clocks a whole frame. It checks the settings at the end of the frame, then drops the line and clocks extra bits to show the settings hold. To observe the shift register MSB on `test_out`, the bench loads test code 01 and then clocks one more bit, which exposes the old T0 at the top of the register. Every frame carries a 1 in the ignored slot, so a decode that reads that slot shows up as a wrong feedback value.

// File: rtl/clk_cfg_loader.sv
module clk_cfg_loader #(
  parameter int M_W   = 9,
  parameter int N_W   = 2,
  parameter int SYNC  = 2,
  parameter int GAP   = 6,
  parameter int M_MIN = 10,
  parameter int M_MAX = 28
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pload_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_dat,
  input  logic           ser_ld,
  input  logic           fb_div_in,
  input  logic           out_clk_in,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_sel,
  output logic           test_out,
  output logic           m_range_err
);
  localparam int FRAME  = 2 + N_W + M_W + 1;
  localparam int M0_POS = FRAME - 3 - N_W;
  localparam logic [M_W-1:0] M_LO = M_W'(M_MIN);
  localparam logic [M_W-1:0] M_HI = M_W'(M_MAX);

  logic [3:0] sy [SYNC];
  logic       sc_d, sl_d;
  logic       p_s, sc, sd, sl, sc_rise, sl_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC; k++) sy[k] <= 4'b1000;
      sc_d <= 1'b0;
      sl_d <= 1'b0;
    end else begin
      sy[0] <= {pload_n, ser_clk, ser_dat, ser_ld};
      for (int k = 1; k < SYNC; k++) sy[k] <= sy[k-1];
      sc_d <= sc;
      sl_d <= sl;
    end
  end

  assign p_s     = sy[SYNC-1][3];
  assign sc      = sy[SYNC-1][2];
  assign sd      = sy[SYNC-1][1];
  assign sl      = sy[SYNC-1][0];
  assign sc_rise = sc & ~sc_d;
  assign sl_rise = sl & ~sl_d;

  logic [FRAME-1:0] sh, sh_nx;
  logic [M_W-1:0]   m_q, m_frm;
  logic [N_W-1:0]   n_q, n_frm;
  logic [1:0]       t_q, t_frm;
  logic             par_mode;

  assign sh_nx = sc_rise ? {sh[FRAME-2:0], sd} : sh;
  assign t_frm = sh_nx[FRAME-1 -: 2];

  always_comb begin
    for (int i = 0; i < N_W; i++) n_frm[N_W-1-i] = sh_nx[FRAME-3-i];
    for (int i = 0; i < M_W; i++) m_frm[i] = sh_nx[M0_POS - i - ((i >= GAP) ? 1 : 0)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q      <= par_m;
      n_q      <= par_n;
      t_q      <= '0;
      sh       <= '0;
      par_mode <= 1'b1;
    end else if (!p_s) begin
      m_q      <= par_m;
      n_q      <= par_n;
      par_mode <= 1'b1;
    end else begin
      sh <= sh_nx;
      if (sl_rise || (sl && sc_rise)) begin
        m_q      <= m_frm;
        n_q      <= n_frm;
        t_q      <= t_frm;
        par_mode <= 1'b0;
      end
    end
  end

  always_comb begin
    case (t_q)
      2'b00:   test_out = 1'b0;
      2'b01:   test_out = sh[FRAME-1];
      2'b10:   test_out = fb_div_in;
      default: test_out = out_clk_in;
    endcase
    if (par_mode) test_out = 1'b0;
  end

  assign m_val       = m_q;
  assign n_sel       = n_q;
  assign m_range_err = (m_q < M_LO) || (m_q > M_HI);
endmodule

module clk_cfg_loader_chk #(
  parameter int FRAME = 14,
  parameter int M_W   = 9,
  parameter int N_W   = 2,
  parameter int M_MIN = 10,
  parameter int M_MAX = 28
) (
  input logic             clk,
  input logic             rst_n,
  input logic             p_s,
  input logic             sl,
  input logic             sc_rise,
  input logic             sl_rise,
  input logic [FRAME-1:0] sh,
  input logic [1:0]       t_q,
  input logic [M_W-1:0]   par_m,
  input logic [N_W-1:0]   par_n,
  input logic [M_W-1:0]   m_val,
  input logic [N_W-1:0]   n_sel,
  input logic             test_out,
  input logic             m_range_err
);
  assert_par_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !p_s |=> (m_val == $past(par_m) && n_sel == $past(par_n)));

  assert_par_test_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !p_s |=> !test_out);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (p_s && !sc_rise && !sl_rise) |=> ($stable(m_val) && $stable(n_sel)));

  assert_no_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (p_s && !sl) |=> ($stable(m_val) && $stable(n_sel)));

  assert_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (p_s && sc_rise) |=> (sh[FRAME-1:1] == $past(sh[FRAME-2:0])));

  assert_code00_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (t_q == 2'b00) |-> !test_out);

  assert_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_val >= M_W'(M_MIN) && m_val <= M_W'(M_MAX)) |-> !m_range_err);

  assert_out_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_val < M_W'(M_MIN)) |-> m_range_err);
endmodule

bind clk_cfg_loader clk_cfg_loader_chk #(
  .FRAME(FRAME), .M_W(M_W), .N_W(N_W), .M_MIN(M_MIN), .M_MAX(M_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .p_s(p_s), .sl(sl), .sc_rise(sc_rise),
  .sl_rise(sl_rise), .sh(sh), .t_q(t_q), .par_m(par_m), .par_n(par_n),
  .m_val(m_val), .n_sel(n_sel), .test_out(test_out), .m_range_err(m_range_err)
);

// File: tb/sim_clk_cfg_loader.sv
module sim_clk_cfg_loader;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pload_n = 1'b1;
  logic [8:0] par_m = 9'd20;
  logic [1:0] par_n = 2'd2;
  logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0;
  logic       fb_div_in = 1'b0, out_clk_in = 1'b0;
  logic [8:0] m_val;
  logic [1:0] n_sel;
  logic       test_out, m_range_err;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  clk_cfg_loader u0 (
    .clk(clk), .rst_n(rst_n), .pload_n(pload_n), .par_m(par_m), .par_n(par_n),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_ld(ser_ld),
    .fb_div_in(fb_div_in), .out_clk_in(out_clk_in),
    .m_val(m_val), .n_sel(n_sel), .test_out(test_out), .m_range_err(m_range_err)
  );

  // vector fields: [13:12] test bits, [11:10] n, [9:1] m, [0] range flag
  localparam logic [13:0] VEC [8] = '{
    {2'd2, 2'd1, 9'd10,  1'b0},
    {2'd3, 2'd3, 9'd28,  1'b0},
    {2'd0, 2'd0, 9'd9,   1'b1},
    {2'd1, 2'd2, 9'd29,  1'b1},
    {2'd3, 2'd1, 9'd511, 1'b1},
    {2'd2, 2'd0, 9'd0,   1'b1},
    {2'd0, 2'd3, 9'd17,  1'b0},
    {2'd1, 2'd1, 9'd341, 1'b1}
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b;
    wait_n(4);
    ser_clk = 1'b1;
    wait_n(4);
    ser_clk = 1'b0;
    wait_n(4);
  endtask

  task automatic send_frame(input logic [1:0] t, input logic [1:0] n, input logic [8:0] m);
    send_bit(t[1]); send_bit(t[0]); send_bit(n[1]); send_bit(n[0]);
    for (int i = 0; i < 6; i++) send_bit(m[i]);
    send_bit(1'b1);
    for (int i = 6; i < 9; i++) send_bit(m[i]);
  endtask

  task automatic pulse_load;
    ser_ld = 1'b1;
    wait_n(6);
    ser_ld = 1'b0;
    wait_n(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wait_n(4);
    check("R1 m at reset", 16'(m_val), 16'd20);
    check("R1 n at reset", 16'(n_sel), 16'd2);
    check("R1 test at reset", 16'(test_out), 16'd0);
    rst_n = 1'b1;
    wait_n(6);
    check("R1 m after reset", 16'(m_val), 16'd20);

    fb_div_in = 1'b1;
    out_clk_in = 1'b1;
    for (int v = 0; v < 8; v++) begin
      logic [1:0] t;
      logic [1:0] n;
      logic [8:0] m;
      logic       e;
      logic       exp_t;
      {t, n, m, e} = VEC[v];
      exp_t = (t == 2'b10 || t == 2'b11) ? 1'b1 : 1'b0;
      send_frame(t, n, m);
      pulse_load;
      check("R4 m from frame", 16'(m_val), 16'(m));
      check("R4 n from frame", 16'(n_sel), 16'(n));
      check("R9 range flag", 16'(m_range_err), 16'(e));
      check("R7 test mux", 16'(test_out), 16'(exp_t));
    end

    send_frame(2'b01, 2'd0, 9'd15);
    pulse_load;
    check("R7 shreg msb T1", 16'(test_out), 16'd0);
    send_bit(1'b0);
    check("R7 shreg msb after shift", 16'(test_out), 16'd1);
    check("R6 m held after extra shift", 16'(m_val), 16'd15);

    send_frame(2'b10, 2'd0, 9'd15);
    pulse_load;
    fb_div_in = 1'b0;
    wait_n(1);
    check("R7 fb low", 16'(test_out), 16'd0);
    fb_div_in = 1'b1;
    wait_n(1);
    check("R7 fb high", 16'(test_out), 16'd1);
    send_frame(2'b11, 2'd0, 9'd15);
    pulse_load;
    out_clk_in = 1'b0;
    wait_n(1);
    check("R7 outclk low", 16'(test_out), 16'd0);
    out_clk_in = 1'b1;
    wait_n(1);
    check("R7 outclk high", 16'(test_out), 16'd1);

    ser_ld = 1'b1;
    wait_n(6);
    send_frame(2'b11, 2'd1, 9'd22);
    check("R5 pass-through m", 16'(m_val), 16'd22);
    check("R5 pass-through n", 16'(n_sel), 16'd1);
    ser_ld = 1'b0;
    wait_n(6);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    check("R6 m held after load low", 16'(m_val), 16'd22);
    check("R6 n held after load low", 16'(n_sel), 16'd1);

    par_m = 9'd12;
    par_n = 2'd3;
    pload_n = 1'b0;
    wait_n(6);
    check("R2 m follows pins", 16'(m_val), 16'd12);
    check("R2 n follows pins", 16'(n_sel), 16'd3);
    check("R8 test low in parallel", 16'(test_out), 16'd0);
    par_m = 9'd25;
    wait_n(6);
    check("R2 m tracks change", 16'(m_val), 16'd25);
    pload_n = 1'b1;
    wait_n(6);
    par_m = 9'd5;
    par_n = 2'd0;
    wait_n(6);
    check("R3 m held", 16'(m_val), 16'd25);
    check("R3 n held", 16'(n_sel), 16'd3);
    check("R8 test still low", 16'(test_out), 16'd0);
    send_frame(2'b11, 2'd2, 9'd27);
    check("R10 m kept without load", 16'(m_val), 16'd25);
    pulse_load;
    check("R4 m after parallel", 16'(m_val), 16'd27);
    check("R8 test released", 16'(test_out), 16'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule